// File: doc/BRIEF.md
# Iterative Reciprocal-Refinement Divider

This block divides an unsigned fractional dividend by a normalized unsigned fractional divisor. It does not produce one quotient digit per step. It first builds a coarse linear estimate of the divisor's reciprocal, good to about four bits. It then sharpens that estimate with a fixed number of Newton-Raphson refinements, X ← X·(2 − B·X), and finally multiplies the refined reciprocal by the dividend.

Each refinement costs two multiplies and one subtract. The number of correct bits roughly doubles per refinement. A single fixed-point multiplier and a single subtractor are time-shared under a small sequencer. Every product is truncated back to a working format that carries extra guard bits beyond the operand width.

A caller presents the operands with a one-cycle start pulse while the block is idle. It receives a one-cycle done pulse when the quotient is ready. The quotient is held until the next division completes. The result is a close approximation: it is neither exactly rounded nor given any special-value handling.

Top module: `nr_recip_div`

## Requirements
- R1: During and right after synchronous reset, busy and done are low and q is zero.
- R2: A start pulse seen while busy is low captures a and b and raises busy on the next cycle. Busy stays high until the cycle in which done is high, inclusive.
- R3: Done is a single-cycle pulse. It appears exactly 3·ITERS+3 clock edges after the edge that accepted start (12 edges at the default ITERS=3).
- R4: Operands a and b are unsigned W-bit fractions of value x/2^W, and b's most significant bit must be 1. Output q is W+1 bits with value q/2^W. At done, q lies within 2 of floor(a·2^W/b).
- R5: q changes only on the cycle where done is high. Between results it holds its value.
- R6: A start pulse while busy is high is ignored. The running division keeps its operands and its latency, and no extra done follows.
- R7: A zero dividend yields q equal to zero.
- R8: The divisor range ends are handled. With b = 0x8000 (one half) the quotient is about 2a. With b = 0xFFFF it is about a.
- R9: Changing a or b after the start cycle has no effect on the division in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division (accepted only when idle) |
| a | input | W | Dividend fraction |
| b | input | W | Divisor fraction, top bit set |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: q is valid |
| q | output | W+1 | Quotient, one integer bit and W fraction bits |

## Verification
A wrong sequencer state shows at the ports first as a wrong done timing. An extra or missing refinement step moves the done pulse by three cycles, and a skipped stage moves it by one. Such faults are visible on the very first division after reset.

A datapath fault of the same kind shows as a quotient error. A wrong seed, a wrong operand selection or a wrong truncation position leaves too few correct bits, or produces a plainly wrong value. This appears in the q value at that same done pulse, and the directed corner operands and the random operands expose it. Busy-time stimulus and held-output checks show whether leaked start pulses or late operand changes corrupt the state.

// File: rtl/nr_div_pkg.sv
`timescale 1ns/1ps
package nr_div_pkg;

    // Seed line constant 2.9142, kept as a ratio of integers
    localparam longint unsigned SEED_NUM = 64'd29142;
    localparam longint unsigned SEED_DEN = 64'd10000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_MUL_BX,
        ST_SUB,
        ST_MUL_X,
        ST_MUL_A,
        ST_DONE
    } nr_state_e;

    typedef enum logic [1:0] {
        MS_BX,
        MS_XT,
        MS_AX
    } mul_sel_e;

    typedef struct packed {
        logic     load;
        logic     seed;
        logic     mul_t;
        logic     sub_t;
        logic     mul_x;
        logic     mul_q;
        mul_sel_e sel;
    } nr_ctl_t;

    // Seed constant scaled by 2^fw
    function automatic logic [63:0] seed_const(input int fw);
        return (SEED_NUM << fw) / SEED_DEN;
    endfunction

endpackage

// File: rtl/nr_ctrl.sv
`timescale 1ns/1ps
module nr_ctrl
    import nr_div_pkg::*;
#(
    parameter int ITERS = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output nr_ctl_t ctl,
    output logic    busy,
    output logic    done
);
    localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1;

    nr_state_e     state;
    logic [IW-1:0] iter;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            iter  <= '0;
        end else begin
            case (state)
                ST_IDLE:   if (start) state <= ST_INIT;
                ST_INIT:   begin
                    state <= ST_MUL_BX;
                    iter  <= '0;
                end
                ST_MUL_BX: state <= ST_SUB;
                ST_SUB:    state <= ST_MUL_X;
                ST_MUL_X:  begin
                    if (iter == IW'(ITERS - 1)) begin
                        state <= ST_MUL_A;
                    end else begin
                        iter  <= iter + 1'b1;
                        state <= ST_MUL_BX;
                    end
                end
                ST_MUL_A:  state <= ST_DONE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl       = '0;
        ctl.load  = (state == ST_IDLE) && start;
        ctl.seed  = (state == ST_INIT);
        ctl.mul_t = (state == ST_MUL_BX);
        ctl.sub_t = (state == ST_SUB);
        ctl.mul_x = (state == ST_MUL_X);
        ctl.mul_q = (state == ST_MUL_A);
        case (state)
            ST_MUL_X: ctl.sel = MS_XT;
            ST_MUL_A: ctl.sel = MS_AX;
            default:  ctl.sel = MS_BX;
        endcase
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);

endmodule

// File: rtl/nr_seed.sv
`timescale 1ns/1ps
module nr_seed
    import nr_div_pkg::*;
#(
    parameter int W  = 16,
    parameter int FW = 24,
    parameter int WB = 26
) (
    input  logic [W-1:0]  b,
    output logic [WB-1:0] x0
);
    localparam logic [WB-1:0] C_SEED = WB'(seed_const(FW));

    // x0 = 2.9142 - 2*b ; b aligned to FW fraction bits, then doubled
    assign x0 = C_SEED - (WB'(b) << (FW - W + 1));

endmodule

// File: rtl/nr_mul.sv
`timescale 1ns/1ps
module nr_mul #(
    parameter int WB = 26,
    parameter int FW = 24
) (
    input  logic [WB-1:0] ma,
    input  logic [WB-1:0] mb,
    output logic [WB-1:0] p
);
    logic [2*WB-1:0] full;

    assign full = {{WB{1'b0}}, ma} * {{WB{1'b0}}, mb};
    assign p    = full[FW +: WB];

endmodule

// File: rtl/nr_recip_div.sv
`timescale 1ns/1ps
module nr_recip_div
    import nr_div_pkg::*;
#(
    parameter int W     = 16,
    parameter int GUARD = 8,
    parameter int ITERS = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W:0]   q
);
    localparam int FW = W + GUARD;
    localparam int WB = FW + 2;
    localparam logic [WB-1:0] TWO = WB'(1) << (FW + 1);

    nr_ctl_t       ctl;
    logic [W-1:0]  a_r, b_r;
    logic [WB-1:0] x_r, t_r, x0;
    logic [WB-1:0] ma, mb, prod;
    logic [WB-1:0] a_w, b_w;
    logic [W:0]    q_r;

    nr_ctrl #(.ITERS(ITERS)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .ctl(ctl), .busy(busy), .done(done)
    );

    nr_seed #(.W(W), .FW(FW), .WB(WB)) u_seed (
        .b(b_r), .x0(x0)
    );

    nr_mul #(.WB(WB), .FW(FW)) u_mul (
        .ma(ma), .mb(mb), .p(prod)
    );

    assign a_w = WB'(a_r) << GUARD;
    assign b_w = WB'(b_r) << GUARD;

    always_comb begin
        case (ctl.sel)
            MS_XT:   begin ma = x_r; mb = t_r; end
            MS_AX:   begin ma = a_w; mb = x_r; end
            default: begin ma = b_w; mb = x_r; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_r <= '0;
            b_r <= '0;
            x_r <= '0;
            t_r <= '0;
            q_r <= '0;
        end else begin
            if (ctl.load) begin
                a_r <= a;
                b_r <= b;
            end
            if (ctl.seed)  x_r <= x0;
            if (ctl.mul_t) t_r <= prod;
            if (ctl.sub_t) t_r <= TWO - t_r;
            if (ctl.mul_x) x_r <= prod;
            if (ctl.mul_q) q_r <= prod[GUARD +: W+1];
        end
    end

    assign q = q_r;

endmodule

// File: rtl/nr_recip_div_chk.sv
`timescale 1ns/1ps
module nr_recip_div_chk #(
    parameter int W     = 16,
    parameter int ITERS = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         busy,
    input logic         done,
    input logic [W:0]   q
);
    localparam int LAT = 3 * ITERS + 3;
    localparam int CW  = $clog2(LAT + 2);

    logic [CW-1:0] cnt;
    logic          a_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            a_zero <= 1'b0;
        end else if (start && !busy) begin
            cnt    <= CW'(1);
            a_zero <= (a == '0);
        end else if (busy && cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && q == '0));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt == CW'(LAT)));

    p_q_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(q) |-> done);

    p_zero_div_r7: assert property (@(posedge clk) disable iff (rst)
        (done && a_zero) |-> (q == '0));

    p_norm_divisor_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |-> b[W-1]);

endmodule

bind nr_recip_div nr_recip_div_chk #(.W(W), .ITERS(ITERS)) u_chk (.*);

// File: tb/tb_nr_recip_div.sv
`timescale 1ns/1ps
module tb_nr_recip_div;
    localparam int W     = 16;
    localparam int ITERS = 3;
    localparam int LAT   = 3 * ITERS + 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = 16'h8000;
    logic         busy, done;
    logic [W:0]   q;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    nr_recip_div #(.W(W), .GUARD(8), .ITERS(ITERS)) dut (
        .clk(clk), .rst(rst), .start(start), .a(a_i), .b(b_i),
        .busy(busy), .done(done), .q(q)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint ref_q(input logic [W-1:0] av, input logic [W-1:0] bv);
        return (longint'(av) << W) / longint'(bv);
    endfunction

    // Run one division; returns quotient and edges from accept to done
    task automatic run_div(input logic [W-1:0] av, input logic [W-1:0] bv,
                           output logic [W:0] qv, output int n);
        @(negedge clk);
        a_i = av; b_i = bv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        n = 1;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        qv = q;
    endtask

    task automatic chk_quot(input logic [W-1:0] av, input logic [W-1:0] bv, input string tag);
        logic [W:0] qv;
        int         n;
        longint     e, d;
        run_div(av, bv, qv, n);
        e = ref_q(av, bv);
        d = longint'(qv) - e;
        if (d < 0) d = -d;
        chk(d <= 2, tag, longint'(qv), e);
        chk(n == LAT, "R3 latency", n, LAT);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && q == '0, "R1 reset state", {busy, done, q}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && q == '0, "R1 after reset", {busy, done, q}, 0);
    endtask

    task automatic t_basic;
        chk_quot(16'hA000, 16'hE000, "R4 five-eighths over seven-eighths");
        chk_quot(16'h1234, 16'hC001, "R4 small over mid");
        chk_quot(16'h7FFF, 16'h8001, "R4 near one");
        @(negedge clk);
        chk(!done, "R3 done single pulse", done, 0);
        chk(!busy, "R2 busy drops after done", busy, 0);
    endtask

    task automatic t_bounds;
        chk_quot(16'h0000, 16'hB000, "R7 zero dividend exact");
        chk(q == '0, "R7 zero quotient", q, 0);
        chk_quot(16'hFFFF, 16'h8000, "R8 divisor one half");
        chk_quot(16'h4321, 16'h8000, "R8 half divisor doubles");
        chk_quot(16'hFFFF, 16'hFFFF, "R8 max divisor");
        chk_quot(16'h0001, 16'hFFFF, "R8 tiny over max");
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] av, bv;
            av = W'($urandom);
            bv = W'($urandom) | 16'h8000;
            chk_quot(av, bv, "R4 random operands");
        end
    endtask

    task automatic t_hold;
        logic [W:0] qv, q0;
        int         n;
        run_div(16'h5555, 16'h9999, qv, n);
        q0 = qv;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(q == q0, "R5 q held while idle", q, q0);
            chk(!done, "R5 no spurious done", done, 0);
        end
    endtask

    task automatic t_busy_start;
        logic [W:0] qv;
        int         n;
        longint     e, d;
        @(negedge clk);
        a_i = 16'h3000; b_i = 16'hF000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        // R9: operands change while busy; R6: start pulses while busy
        a_i = 16'hFFFF; b_i = 16'h8000;
        @(negedge clk); n++;
        start = 1'b1;
        @(negedge clk); n++;
        start = 1'b0;
        @(negedge clk); n++;
        start = 1'b1;
        @(negedge clk); n++;
        start = 1'b0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        qv = q;
        e = ref_q(16'h3000, 16'hF000);
        d = longint'(qv) - e;
        if (d < 0) d = -d;
        chk(d <= 2, "R9 operands captured at start", longint'(qv), e);
        chk(n == LAT, "R6 latency unchanged by busy start", n, LAT);
        for (int i = 0; i < LAT + 2; i++) begin
            @(negedge clk);
            chk(!done && !busy, "R6 no second division", {busy, done}, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_bounds();
        t_hold();
        t_busy_start();
        t_random();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule